// File: doc/BRIEF.md
# BCD Alarm Comparator with Per-Field Wildcards

This block watches six live calendar fields from a time counter (seconds, minutes, hours, day of week, day of month and month, each in BCD) and compares them against six programmable alarm bytes. Every alarm byte carries its own enable in its top bit. A field whose enable is clear is a wildcard, so software can ask for an alarm at "every minute at second 30" or "the 12th of each month" just by choosing which bytes to arm.

The comparison is sampled only on the one-cycle seconds-update strobe from the counter. When every armed field equals the live value, a sticky alarm flag is set. The flag drives an interrupt output when the alarm interrupt enable is set. Software programs the alarm bytes and the control byte over a simple write/read register bus, and clears the flag by writing zero to it. The time counter itself and any year comparison are outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every alarm byte reads 0x00, the control byte (index 14) reads 0x00 and `alarmIrq` is low.
- R2: The alarm bytes sit at register indices 8 (seconds), 9 (minutes), 10 (hours), 11 (day of week), 12 (day of month) and 13 (month). Each reads back the full 8 bits last written to it. A write to any other index changes no alarm byte and reads back 0x00.
- R3: An alarm byte with bit 7 clear takes no part in the match, whatever its bits 6:0 hold. Writing 0x00 disarms that field.
- R4: The alarm flag (control bit 0) becomes 1 at the clock edge where `secTick` is high and every armed field's bits 6:0 equal the matching time input. It is read one cycle later. Without `secTick` the flag never sets.
- R5: With no alarm byte armed, the flag never sets, even when the time inputs equal the stored values.
- R6: The flag is sticky. A later non-matching tick leaves it set, and so does writing 1 to control bit 0. Only writing 0 to control bit 0 clears it.
- R7: Control bit 3 is the alarm interrupt enable. `alarmIrq` is high exactly when both the flag and that enable are 1.
- R8: One control write can clear the flag and the enable together. If a matching tick falls in the same cycle as a flag-clearing write, the flag is set.
- R9: A mismatch in any single armed field prevents the set. The month field compares BCD codes 0x01 to 0x12, so month 0x11 does not match an alarm of 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register index for write and read |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Read data for `busAddr` (combinational) |
| secTick | input | 1 | One-cycle pulse on each seconds update of the counter |
| timeSec | input | 7 | Live seconds, BCD |
| timeMin | input | 7 | Live minutes, BCD |
| timeHour | input | 7 | Live hours, BCD |
| timeWday | input | 7 | Live day of week, BCD |
| timeDay | input | 7 | Live day of month, BCD |
| timeMon | input | 7 | Live month, BCD 0x01 to 0x12 |
| alarmIrq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `secTick` is a single-cycle pulse, that the time inputs hold still around each tick, and that a bus write addresses one register at a time. They check flag setting, stickiness and clearing, and that an alarm byte changes only under its own write strobe. The bench drives every input one time unit after a rising edge and changes the time fields only between ticks, so each comparison sees settled values. It pairs a flag-clearing write with a matching tick on purpose, to exercise the set-wins rule.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam int ADDR_W     = 4;
  localparam int ALARM_BASE = 8;
  localparam int CTRL_IDX   = 14;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;
  localparam int VAL_W      = FIELD_W - 1;
  localparam int EN_BIT     = FIELD_W - 1;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldWr;
  } dp_strobe_t;
endpackage

// File: rtl/alarm_cmp_datapath.sv
module alarm_cmp_datapath
  import alarm_cmp_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dp_strobe_t                             strb,
  input  logic [FIELD_W-1:0]                     wrData,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0]       timeVec,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]     alarmRegs,
  output logic                                   matchHit
);
  logic [NUM_FIELDS-1:0] enMask;
  logic [NUM_FIELDS-1:0] eqVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmRegs <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (strb.fieldWr[i]) alarmRegs[i] <= wrData;
      end
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    assign enMask[g] = alarmRegs[g][EN_BIT];
    assign eqVec[g]  = !enMask[g] || (alarmRegs[g][VAL_W-1:0] == timeVec[g]);

    // R2: an alarm byte only moves under its own write strobe
    p_field_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strb.fieldWr[g] |=> $stable(alarmRegs[g]));
    p_field_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb.fieldWr[g] |=> (alarmRegs[g] == $past(wrData)));
  end

  // armed fields must exist, and all of them must agree
  assign matchHit = (|enMask) && (&eqVec);
endmodule

// File: rtl/alarm_cmp_ctrl.sv
module alarm_cmp_ctrl
  import alarm_cmp_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   busWrEn,
  input  logic [ADDR_W-1:0]                      busAddr,
  input  logic [FIELD_W-1:0]                     busWrData,
  input  logic                                   secTick,
  input  logic                                   matchHit,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]     alarmRegs,
  output dp_strobe_t                             strb,
  output logic                                   flagQ,
  output logic                                   ieQ,
  output logic [FIELD_W-1:0]                     busRdData
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);

  logic ctrlWr;
  logic setEv;
  logic unusedWd;

  assign ctrlWr   = busWrEn && (busAddr == CTRL_A);
  assign setEv    = secTick && matchHit;
  assign unusedWd = ^busWrData;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gDec
    localparam logic [ADDR_W-1:0] FIELD_A = ADDR_W'(ALARM_BASE + g);
    assign strb.fieldWr[g] = busWrEn && (busAddr == FIELD_A);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      ieQ   <= 1'b0;
    end else begin
      if (setEv)       flagQ <= 1'b1;
      else if (ctrlWr) flagQ <= flagQ & busWrData[FLAG_BIT];
      if (ctrlWr)      ieQ   <= busWrData[IE_BIT];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == CTRL_A) begin
      busRdData[FLAG_BIT] = flagQ;
      busRdData[IE_BIT]   = ieQ;
    end
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (busAddr == ADDR_W'(ALARM_BASE + i)) busRdData = alarmRegs[i];
    end
  end

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.fieldWr));
  p_set_on_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && matchHit) |=> flagQ);
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(secTick && matchHit));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(ctrlWr && !busWrData[FLAG_BIT])) |=> flagQ);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !busWrData[FLAG_BIT] && !setEv) |=> !flagQ);
  p_ie_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !busWrData[IE_BIT]) |=> !ieQ);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [3:0]  busAddr,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        secTick,
  input  logic [6:0]  timeSec,
  input  logic [6:0]  timeMin,
  input  logic [6:0]  timeHour,
  input  logic [6:0]  timeWday,
  input  logic [6:0]  timeDay,
  input  logic [6:0]  timeMon,
  output logic        alarmIrq
);
  dp_strobe_t                           strb;
  logic [NUM_FIELDS-1:0][VAL_W-1:0]     timeVec;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   alarmRegs;
  logic                                 matchHit;
  logic                                 flagQ;
  logic                                 ieQ;

  assign timeVec = {timeMon, timeDay, timeWday, timeHour, timeMin, timeSec};

  alarm_cmp_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .timeVec   (timeVec),
    .alarmRegs (alarmRegs),
    .matchHit  (matchHit)
  );

  alarm_cmp_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .secTick   (secTick),
    .matchHit  (matchHit),
    .alarmRegs (alarmRegs),
    .strb      (strb),
    .flagQ     (flagQ),
    .ieQ       (ieQ),
    .busRdData (busRdData)
  );

  assign alarmIrq = flagQ && ieQ;
endmodule

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       secTick = 1'b0;
  logic [6:0] tSec = '0, tMin = '0, tHour = '0, tWday = '0, tDay = '0, tMon = '0;
  logic       alarmIrq;

  alarm_match_unit dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .secTick(secTick),
    .timeSec(tSec), .timeMin(tMin), .timeHour(tHour), .timeWday(tWday),
    .timeDay(tDay), .timeMon(tMon), .alarmIrq(alarmIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    string      tag;
  } item_t;

  item_t q[$];
  bit    obsReq = 1'b0;
  bit    done = 1'b0;
  int    checks = 0;
  int    errors = 0;

  logic [7:0] mAlarm [6];
  logic       mFlag, mIe;

  function automatic logic [6:0] tv(int i);
    case (i)
      0: return tSec;
      1: return tMin;
      2: return tHour;
      3: return tWday;
      4: return tDay;
      default: return tMon;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (obsReq) begin
      if (q.size() == 0) begin
        errors++;
        checks++;
        $display("FAIL scoreboard empty: rd=%h expected an item", busRdData);
      end else begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (busRdData !== it.rd || alarmIrq !== it.irq) begin
          errors++;
          $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                   it.tag, busRdData, alarmIrq, it.rd, it.irq);
        end
      end
    end
  end

  task automatic step(bit doWr, logic [3:0] a, logic [7:0] d, bit doTick);
    bit hit = 1'b1;
    bit any = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (mAlarm[i][7]) begin
        any = 1'b1;
        if (mAlarm[i][6:0] != tv(i)) hit = 1'b0;
      end
    end
    hit = hit && any && doTick;
    @(posedge clk); #1;
    busWrEn = doWr; busAddr = a; busWrData = d; secTick = doTick;
    @(posedge clk); #1;
    busWrEn = 1'b0; secTick = 1'b0;
    if (doWr) begin
      if (a >= 4'd8 && a <= 4'd13) mAlarm[int'(a) - 8] = d;
      else if (a == 4'd14) begin
        mIe = d[3];
        mFlag = mFlag & d[0];
      end
    end
    if (hit) mFlag = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic tick();
    step(1'b0, 4'd0, 8'd0, 1'b1);
  endtask

  task automatic push(logic [3:0] a, logic [7:0] rd, logic irq, string tag);
    item_t it;
    it.rd = rd; it.irq = irq; it.tag = tag;
    q.push_back(it);
    busAddr = a;
    obsReq = 1'b1;
    @(negedge clk); #1;
    obsReq = 1'b0;
  endtask

  // expected value from the bench's own register model
  task automatic chk(logic [3:0] a, string tag);
    logic [7:0] e = 8'h00;
    if (a >= 4'd8 && a <= 4'd13) e = mAlarm[int'(a) - 8];
    else if (a == 4'd14) e = {4'b0, mIe, 2'b0, mFlag};
    push(a, e, mFlag & mIe, tag);
  endtask

  task automatic setTime(logic [6:0] s, logic [6:0] mi, logic [6:0] h,
                         logic [6:0] w, logic [6:0] dd, logic [6:0] mo);
    tSec = s; tMin = mi; tHour = h; tWday = w; tDay = dd; tMon = mo;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mAlarm[i] = 8'h00;
    mFlag = 1'b0; mIe = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    push(4'd14, 8'h00, 1'b0, "R1 control after reset");
    push(4'd8, 8'h00, 1'b0, "R1 seconds alarm after reset");
    push(4'd13, 8'h00, 1'b0, "R1 month alarm after reset");

    // R2 program and read back
    wr(4'd8, 8'hB0); wr(4'd9, 8'h95); wr(4'd10, 8'h88);
    wr(4'd11, 8'h83); wr(4'd12, 8'hA7); wr(4'd13, 8'h92);
    for (int a = 8; a <= 13; a++) chk(4'(a), "R2 alarm readback");
    wr(4'd3, 8'h5A);
    push(4'd3, 8'h00, 1'b0, "R2 unmapped index reads zero");
    chk(4'd8, "R2 seconds alarm untouched by stray write");

    // R4 no tick, no set
    setTime(7'h30, 7'h15, 7'h08, 7'h03, 7'h27, 7'h12);
    repeat (4) step(1'b0, 4'd0, 8'd0, 1'b0);
    push(4'd14, 8'h00, 1'b0, "R4 matching time without tick");

    // R9 single mismatch
    tSec = 7'h31; tick();
    push(4'd14, 8'h00, 1'b0, "R9 seconds mismatch");

    // R4 matching tick
    tSec = 7'h30; tick();
    push(4'd14, 8'h01, 1'b0, "R4 flag set, interrupt disabled");

    // R7 interrupt enable
    wr(4'd14, 8'h09);
    push(4'd14, 8'h09, 1'b1, "R7 flag and enable give interrupt");
    wr(4'd14, 8'h01);
    push(4'd14, 8'h01, 1'b0, "R7 enable off masks interrupt");

    // R6 stickiness
    wr(4'd14, 8'h09);
    tSec = 7'h45; tick();
    push(4'd14, 8'h09, 1'b1, "R6 flag survives non-matching tick");

    // R8 clear both in one write
    wr(4'd14, 8'h00);
    push(4'd14, 8'h00, 1'b0, "R8 flag and enable cleared together");

    // R3 disarmed fields
    wr(4'd10, 8'h00); wr(4'd11, 8'h05);
    setTime(7'h30, 7'h15, 7'h21, 7'h06, 7'h27, 7'h12);
    tick();
    push(4'd14, 8'h01, 1'b0, "R3 disarmed hour and weekday ignored");
    chk(4'd11, "R3 disarmed weekday readback");

    // R8 set wins over a clearing write in the same cycle
    step(1'b1, 4'd14, 8'h00, 1'b1);
    push(4'd14, 8'h01, 1'b0, "R8 matching tick beats clear");
    wr(4'd14, 8'h08);
    push(4'd14, 8'h08, 1'b0, "R8 clear with enable set");
    wr(4'd14, 8'h09);
    push(4'd14, 8'h08, 1'b0, "R6 writing one does not set flag");

    // R5 nothing armed
    for (int a = 8; a <= 13; a++) wr(4'(a), 8'h00);
    setTime(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
    tick(); tick();
    push(4'd14, 8'h08, 1'b0, "R5 no armed field never fires");

    // R9 month compare
    wr(4'd13, 8'h92);
    tMon = 7'h11; tick();
    push(4'd14, 8'h08, 1'b0, "R9 month 0x11 vs alarm 0x12");
    tMon = 7'h12; tick();
    push(4'd14, 8'h09, 1'b1, "R9 month 0x12 matches");
    chk(4'd14, "R9 model agrees");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule